// File: doc/BRIEF.md
# Single-Operation Subtract-and-Branch Processor

This block is a very small processor with one operation and no opcode. Memory holds words, and each instruction takes three of them in a row: a source address `A`, a destination address `B` and a target `C`. The core reads `M[A]` and `M[B]`, writes `M[B] - M[A]` back to `B`, and then goes to `C` if the new value is zero or negative. Otherwise it goes on to the instruction that starts three words later. Any program can be built from this one operation by arranging the memory contents.

Operand values whose sign bit is set are never used as memory addresses. If `A` is negative, the core takes one byte from an input handshake port in place of `M[A]`. If `B` is negative, the core sends the low byte of the source value out on an output handshake port and skips the memory write. If a branch to a negative `C` is taken, the core halts. It stays halted and issues no memory traffic until reset.

The memory port is synchronous: read data for a request comes back on the clock after the request. Each instruction passes through the states FETCH_A, FETCH_B, FETCH_C, READ_A, READ_B, WRITE and UPDATE. Each state takes one cycle unless a handshake stalls it. The transitions are:
- FETCH_A→FETCH_B→FETCH_C→READ_A.
- READ_A→READ_B. When `A` is negative, this happens only once an input byte is accepted.
- READ_B→WRITE.
- WRITE→UPDATE. When `B` is negative, this happens only once the output byte is accepted.
- UPDATE→HALT when the branch is taken to a negative target.
- UPDATE→FETCH_A in every other case.
- HALT→HALT.

Top module: `subleq_core`

## Requirements
- R1: During and right after reset, `halted` is low, no write is requested, and the first request is a read of address 0.
- R2: Each instruction starts with three read requests, at addresses PC, PC+1 and PC+2, in consecutive cycles.
- R3: When `B` is not negative, the core writes `M[B] - M[A]` to address `B`. The subtraction is two's complement and wraps at the word width.
- R4: The branch is taken when the written difference, read as a signed number, is zero or negative. A taken branch sets the PC to the low address bits of `C`.
- R5: When the branch is not taken, the PC advances by exactly 3.
- R6: When `A` is negative, the core raises `in_ready` and makes no memory request until `in_valid` is seen. It consumes exactly one byte.
- R7: The input byte is zero-extended to the word width before it is subtracted.
- R8: When `B` is negative, the low byte of the source value is presented on `out_data` and no memory write happens. The branch is then never taken.
- R9: A waiting handshake holds steady. `in_ready` stays high, `out_valid` stays high and `out_data` does not change until the other side accepts.
- R10: The core halts only when a branch is taken to a negative target. A negative target on a branch that is not taken has no effect. Once halted, `halted` stays high until reset and `mem_req` stays low.
- R11: Without stalls, an instruction takes 7 cycles. A program of `n` instructions whose last instruction halts raises `halted` 7·n cycles after reset is released. Each cycle of input or output stall adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid the cycle after a read request |
| in_data | input | IO_W | Input port byte |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Core is taking an input byte |
| out_data | output | IO_W | Output port byte |
| out_valid | output | 1 | Output byte presented |
| out_ready | input | 1 | Receiver accepts the output byte |
| halted | output | 1 | Core has stopped |

## Verification
The assertions assume that memory returns data exactly one cycle after each read request. They also assume that the handshake partners drive `in_valid` and `out_ready` as clean levels, sampled at the clock edge.

The bench models memory with a one-cycle registered read that updates only on requests, so the first assumption holds. The bench changes the handshake inputs only on falling edges, and it changes them by cycle number, so the second assumption holds. The stall windows are placed so that the exact halt cycle can be computed.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_A,
        ST_FETCH_B,
        ST_FETCH_C,
        ST_READ_A,
        ST_READ_B,
        ST_WRITE,
        ST_UPDATE,
        ST_HALT
    } state_t;

    // Where the read data returned next cycle is to be captured
    typedef enum logic [2:0] {
        DST_NONE,
        DST_A,
        DST_B,
        DST_C,
        DST_OPA,
        DST_OPB
    } dst_t;

    localparam int unsigned INSTR_WORDS = 3;

endpackage

// File: rtl/subleq_alu.sv
module subleq_alu #(
    parameter int unsigned WORD_W = 16
) (
    input  logic [WORD_W-1:0] minuend,
    input  logic [WORD_W-1:0] subtrahend,
    output logic [WORD_W-1:0] diff,
    output logic              le_zero
);

    always_comb begin
        diff    = minuend - subtrahend;
        le_zero = diff[WORD_W-1] | (diff == '0);
    end

endmodule

// File: rtl/subleq_fsm.sv
module subleq_fsm
    import subleq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   a_neg,
    input  logic   b_neg,
    input  logic   c_neg,
    input  logic   take,
    input  logic   in_valid,
    input  logic   out_ready,
    output state_t state,
    output logic   mem_req,
    output logic   mem_we,
    output logic   in_ready,
    output logic   out_valid,
    output dst_t   rd_dst
);

    state_t state_q;
    state_t state_d;

    assign state = state_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH_A;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH_A: state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = ST_FETCH_C;
            ST_FETCH_C: state_d = ST_READ_A;
            ST_READ_A:  if (!a_neg || in_valid)  state_d = ST_READ_B;
            ST_READ_B:  state_d = ST_WRITE;
            ST_WRITE:   if (!b_neg || out_ready) state_d = ST_UPDATE;
            ST_UPDATE:  state_d = (take && c_neg) ? ST_HALT : ST_FETCH_A;
            ST_HALT:    state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        rd_dst    = DST_NONE;
        unique case (state_q)
            ST_FETCH_A: begin
                mem_req = 1'b1;
                rd_dst  = DST_A;
            end
            ST_FETCH_B: begin
                mem_req = 1'b1;
                rd_dst  = DST_B;
            end
            ST_FETCH_C: begin
                mem_req = 1'b1;
                rd_dst  = DST_C;
            end
            ST_READ_A: begin
                if (a_neg) begin
                    in_ready = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    rd_dst  = DST_OPA;
                end
            end
            ST_READ_B: begin
                if (!b_neg) begin
                    mem_req = 1'b1;
                    rd_dst  = DST_OPB;
                end
            end
            ST_WRITE: begin
                if (b_neg) begin
                    out_valid = 1'b1;
                end else begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
            end
            ST_UPDATE: begin
            end
            ST_HALT: begin
            end
        endcase
    end

endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [IO_W-1:0]   out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              halted
);

    localparam int unsigned SIGN = WORD_W - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_WORDS);

    state_t            state_q;
    dst_t              rd_dst;
    dst_t              rd_dst_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] a_addr_q;
    logic [ADDR_W-1:0] b_addr_q;
    logic [ADDR_W-1:0] c_addr_q;
    logic              a_neg_q;
    logic              b_neg_q;
    logic              c_neg_q;
    logic [WORD_W-1:0] opa_q;
    logic              take_q;
    logic [WORD_W-1:0] diff;
    logic              le_zero;

    subleq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .a_neg     (a_neg_q),
        .b_neg     (b_neg_q),
        .c_neg     (c_neg_q),
        .take      (take_q),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .state     (state_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .rd_dst    (rd_dst)
    );

    subleq_alu #(.WORD_W(WORD_W)) u_alu (
        .minuend    (mem_rdata),
        .subtrahend (opa_q),
        .diff       (diff),
        .le_zero    (le_zero)
    );

    // address selection per state
    always_comb begin
        unique case (state_q)
            ST_FETCH_A: mem_addr = pc_q;
            ST_FETCH_B: mem_addr = pc_q + ADDR_W'(1);
            ST_FETCH_C: mem_addr = pc_q + ADDR_W'(2);
            ST_READ_A:  mem_addr = a_addr_q;
            ST_READ_B:  mem_addr = b_addr_q;
            ST_WRITE:   mem_addr = b_addr_q;
            ST_UPDATE:  mem_addr = pc_q;
            ST_HALT:    mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = diff;
    assign out_data  = opa_q[IO_W-1:0];
    assign halted    = (state_q == ST_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            rd_dst_q <= DST_NONE;
            a_addr_q <= '0;
            b_addr_q <= '0;
            c_addr_q <= '0;
            a_neg_q  <= 1'b0;
            b_neg_q  <= 1'b0;
            c_neg_q  <= 1'b0;
            opa_q    <= '0;
            take_q   <= 1'b0;
        end else begin
            rd_dst_q <= rd_dst;
            unique case (rd_dst_q)
                DST_A: begin
                    a_addr_q <= mem_rdata[ADDR_W-1:0];
                    a_neg_q  <= mem_rdata[SIGN];
                end
                DST_B: begin
                    b_addr_q <= mem_rdata[ADDR_W-1:0];
                    b_neg_q  <= mem_rdata[SIGN];
                end
                DST_C: begin
                    c_addr_q <= mem_rdata[ADDR_W-1:0];
                    c_neg_q  <= mem_rdata[SIGN];
                end
                DST_OPA: opa_q <= mem_rdata;
                default: begin
                end
            endcase
            if (in_ready && in_valid) begin
                opa_q <= WORD_W'(in_data);
            end
            if (state_q == ST_WRITE) begin
                take_q <= !b_neg_q && le_zero;
            end
            if (state_q == ST_UPDATE && !(take_q && c_neg_q)) begin
                pc_q <= take_q ? c_addr_q : pc_q + STEP;
            end
        end
    end

endmodule

// File: rtl/subleq_core_chk.sv
module subleq_core_chk
    import subleq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned IO_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input state_t            state,
    input logic [ADDR_W-1:0] pc,
    input logic              take,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [IO_W-1:0]   out_data,
    input logic              halted
);

    a_r2_consecutive_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH_B) |-> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UPDATE && !take) |=> (pc == $past(pc) + ADDR_W'(3)));

    a_r6_no_mem_on_input: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !mem_req);

    a_r8_no_write_on_output: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_we);

    a_r9_in_hold: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> in_ready);

    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_req);

    a_r3_single_write: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

bind subleq_core subleq_core_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_q),
    .pc        (pc_q),
    .take      (take_q),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .halted    (halted)
);

// File: tb/test_subleq_core.sv
module test_subleq_core;

    localparam int W         = 16;
    localparam int AW        = 8;
    localparam int RUN_LIMIT = 400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    out_data;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          halted;

    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0]  ld_data = '0;
    logic [W-1:0]  mem [256];

    int compared = 0;
    int mismatched = 0;
    int in_n, out_n;
    int out_log [8];
    bit done = 1'b0;

    always #5 clk = ~clk;

    subleq_core i_subleq_core (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .halted    (halted)
    );

    // behavioural memory: registered read, one cycle latency
    always @(posedge clk) begin
        if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = AW'(a);
        ld_data = W'(d);
    endtask

    task automatic clear_mem();
        rst = 1'b1;
        for (int i = 0; i < 40; i++) poke(i, 0);
    endtask

    function automatic int sword(input logic [W-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic run(input int in_at, input int out_at, output int hcyc);
        int  c;
        bit  req_after;
        @(negedge clk);
        ld_en = 1'b0;
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        c = 0;
        hcyc = -1;
        in_n = 0;
        out_n = 0;
        req_after = 1'b0;
        forever begin
            in_valid  = (c >= in_at);
            out_ready = (c >= out_at);
            #1;
            if (c == 0) begin
                // R1 reset state
                chk("R1", "first req", int'(mem_req), 1);
                chk("R1", "first addr", int'(mem_addr), 0);
                chk("R1", "first we", int'(mem_we), 0);
                chk("R1", "halted after reset", int'(halted), 0);
            end
            if (in_valid && in_ready) in_n++;
            if (out_valid && out_ready) begin
                if (out_n < 8) out_log[out_n] = int'(out_data);
                out_n++;
            end
            if (hcyc < 0 && halted) hcyc = c;
            if (hcyc >= 0 && (mem_req || !halted)) req_after = 1'b1;
            if (hcyc >= 0 && c >= hcyc + 3) break;
            if (c >= RUN_LIMIT) break;
            @(negedge clk);
            c++;
        end
        in_valid = 1'b0;
        out_ready = 1'b0;
        chk("R10", "quiet and sticky after halt", int'(req_after), 0);
    endtask

    initial begin
        int hc;
        int vals [9] = '{-3, -2, -1, 0, 1, 2, 3, 32767, -32768};

        // R3 R4 R5 R11: sweep of one subtract-branch over signed operand pairs
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                logic signed [W-1:0] d;
                d = W'(vals[j] - vals[i]);
                clear_mem();
                poke(0, 10); poke(1, 11); poke(2, 6);
                poke(3, 12); poke(4, 12); poke(5, -1);
                poke(6, 13); poke(7, 14); poke(8, -1);
                poke(10, vals[i]); poke(11, vals[j]); poke(13, 1);
                run(0, 0, hc);
                chk("R3", "difference written to B", sword(mem[11]), int'(d));
                chk("R4", "taken marker", sword(mem[14]), (d <= 0) ? -1 : 0);
                chk("R3", "source word untouched", sword(mem[10]), int'(W'(vals[i]) == W'(vals[i]) ? $signed(W'(vals[i])) : 0));
                chk("R11", "halt cycle two instructions", hc, 14);
                chk("R6", "no input taken", in_n, 0);
                chk("R8", "no output sent", out_n, 0);
            end
        end

        // R10: not taken with a negative target does not halt; R5 fall-through
        clear_mem();
        poke(0, 15); poke(1, 16); poke(2, -1);
        poke(3, 12); poke(4, 12); poke(5, -1);
        poke(15, 1); poke(16, 5);
        run(0, 0, hc);
        chk("R10", "halt only after taken branch", hc, 14);
        chk("R5", "fall-through result", sword(mem[16]), 4);

        // R8 R2 R11: countdown loop with output port, counts 1..6
        for (int n = 1; n <= 6; n++) begin
            clear_mem();
            poke(0, 21); poke(1, 20); poke(2, 9);
            poke(3, 20); poke(4, -1); poke(5, 6);
            poke(6, 12); poke(7, 12); poke(8, 0);
            poke(9, 12); poke(10, 12); poke(11, -1);
            poke(20, n); poke(21, 1);
            run(0, 0, hc);
            chk("R11", "countdown halt cycle", hc, 7 * (3 * n - 1));
            chk("R8", "output count", out_n, n - 1);
            for (int k = 0; k < n - 1 && k < 8; k++)
                chk("R8", "output byte", out_log[k], n - 1 - k);
            chk("R3", "counter final", sword(mem[20]), 0);
            chk("R8", "output cell untouched", sword(mem[4]), -1);
        end

        // R6 R7 R9 R11: input then output with stalls
        for (int v = 0; v < 2; v++) begin
            int inb, ina, outa, exp_cell;
            inb  = (v == 0) ? 7 : 200;
            ina  = (v == 0) ? 10 : 0;
            outa = (v == 0) ? 25 : 0;
            exp_cell = 100 - inb;
            clear_mem();
            poke(0, -1); poke(1, 30); poke(2, 3);
            poke(3, 30); poke(4, -1); poke(5, 6);
            poke(6, 12); poke(7, 12); poke(8, -1);
            poke(30, 100);
            in_data = 8'(inb);
            run(ina, outa, hc);
            chk("R7", "input zero-extended subtraction", sword(mem[30]), exp_cell);
            chk("R6", "one input byte", in_n, 1);
            chk("R8", "one output byte", out_n, 1);
            chk("R8", "output byte value", out_log[0], exp_cell & 255);
            chk("R9", "halt cycle with stalls", hc, (v == 0) ? 34 : 21);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule